// File: doc/BRIEF.md
# Framebuffer Fetch Sequencer

This block prepares each frame of an LCD controller's scan-out before any pixel data is moved. When the controller is switched on, it checks the programmed buffer addresses and latches the two buffer bases. Unless the load mode says the buffers hold pixels only, it then streams a 256-entry, 16-bit colour table out of the start of the active buffer. On every frame tick it reloads that table and reads the colour depth out of its first entry. From the depth it works out where the pixels begin and how many bytes the frame needs. If the frame does not fit in the buffer, the block stops with a sync error. Otherwise it publishes a frame descriptor: pixel base, bits per pixel, line stride, first line and line count.

The surrounding controller feeds it live register fields, one validity flag for each buffer address, and a frame strobe. Table words arrive through a request/grant read port whose data returns on a separate valid strobe. The words are forwarded on a write strobe to whatever holds the colour table. In dual-buffer mode each accepted frame flips the active buffer, so a display can be double-buffered without software touching the bases.

Top module: `fbf_seq`

## Requirements
- R1: After reset, run_o, rd_req_o and every pulse output (pal_wr_o, pal_done_o, frame_go_o, frame_skip_o, sync_err_o, err_irq_o, cond_set_o) are 0.
- R2: On a rising edge of en_req_i, the needed address flags are checked: addr_ok_i bits 0 and 1 always, and bits 2 and 3 as well when dual_i is 1. If any needed flag is 0, the block pulses cond_set_o bit 2, pulses err_irq_o only when err_irq_en_i is 1, and leaves run_o at 0. Otherwise run_o becomes 1, the bases top0_i/top1_i are latched and buffer 0 becomes current.
- R3: At start-up, unless load_mode_i is 2, the block reads 256 words from buffer 0 at byte addresses base + 2*i. Each returned word i is forwarded on pal_wr_o with pal_idx_o = i and pal_data_o equal to the word, and pal_done_o pulses once after word 255. With load_mode_i = 2 no read is issued.
- R4: Once rd_req_o is raised, it and rd_addr_o hold steady until rd_gnt_i is seen. Exactly 256 grants are taken for each table load.
- R5: While running, each tick_i with load_mode_i equal to 0 or 3 reloads the table from the current buffer's base and then evaluates the frame. With load_mode_i = 2 the frame is evaluated at once, using the depth code latched last.
- R6: The depth code is bits 14:12 of table word 0. Codes 1, 2 and 3 give 2, 4 and 8 bits per pixel, and codes 4 to 7 give 16. Code 0 gives a frame_skip_o pulse and no descriptor.
- R7: The header offset is 0x200 bytes for codes 3 to 7, 0x20 bytes for codes 0 to 2, and 0 when load_mode_i is 2. pix_base_o = current base + offset, and stride_o = (width * bpp) / 8, with width = width_m1_i + 1.
- R8: The frame needs offset + width*height*bpp/8 bytes, with height = height_m1_i + 1. If this exceeds (bottom - top) + 2 of the current buffer, or if bottom < top, sync_err_o pulses and run_o drops. Further ticks are then ignored until en_req_i goes low and rises again. The arithmetic holds exactly for 1024x1024 at 16 bpp.
- R9: An accepted frame pulses frame_go_o together with cond_set_o bit (current buffer), with bit 0 for buffer 0 and bit 1 for buffer 1. With dual_i set, the current buffer then flips. Without it, buffer 0 stays current.
- R10: With subpanel_i bit 31 set, bits 25:16 give a line value. If bit 29 is also set, first_line_o takes that value and line_cnt_o is the height. If bit 29 is clear, first_line_o is 0 and line_cnt_o takes the value. With bit 31 clear, first_line_o is 0 and line_cnt_o is the height.
- R11: With load_mode_i = 1, ticks cause no read and no frame outcome.
- R12: Dropping en_req_i while waiting for a tick makes run_o fall. The next enable starts again from buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_req_i | input | 1 | Controller enable level |
| load_mode_i | input | 2 | 0/3 table+pixels, 1 no output, 2 pixels only |
| dual_i | input | 1 | Alternate between two buffers |
| err_irq_en_i | input | 1 | Mask for the address error interrupt |
| width_m1_i | input | LW | Frame width minus one |
| height_m1_i | input | LW | Frame height minus one |
| subpanel_i | input | 32 | Line window control word |
| top0_i | input | AW | Buffer 0 start address |
| bot0_i | input | AW | Buffer 0 end address |
| top1_i | input | AW | Buffer 1 start address |
| bot1_i | input | AW | Buffer 1 end address |
| addr_ok_i | input | 4 | Validity of top0, bot0, top1, bot1 |
| tick_i | input | 1 | Frame strobe |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_gnt_i | input | 1 | Request accepted |
| rd_vld_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| pal_wr_o | output | 1 | Colour table word strobe |
| pal_idx_o | output | log2(PAL_N) | Colour table index |
| pal_data_o | output | DW | Colour table word |
| pal_done_o | output | 1 | Start-up table load finished |
| run_o | output | 1 | Sequencer running |
| frame_go_o | output | 1 | Frame descriptor valid |
| frame_skip_o | output | 1 | Frame skipped, depth code 0 |
| sync_err_o | output | 1 | Frame overflowed its buffer |
| cond_set_o | output | 3 | Buffer done bits 0/1, address error bit 2 |
| err_irq_o | output | 1 | Address error interrupt |
| pix_base_o | output | AW | First pixel byte address |
| bpp_o | output | 5 | Bits per pixel |
| stride_o | output | LW+3 | Bytes per line |
| first_line_o | output | LW | First displayed line |
| line_cnt_o | output | LW+1 | Number of displayed lines |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16-bit words, 10-bit line fields and a 256-entry table. The 10-bit line fields make a 1024x1024 frame at 16 bpp reachable, and the fit check is driven on both sides of its 2-byte slack with the full 2 MiB product. The full 256-word load runs with and without grant stalls. Dual-buffer alternation and the depth code kept over into pixel-only mode are both exercised.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_WAIT,
    S_EVAL
  } seq_st_t;

  localparam logic [1:0] LM_OFF     = 2'd1;
  localparam logic [1:0] LM_PIXONLY = 2'd2;

  localparam logic [9:0] HDR_SHORT = 10'h020;
  localparam logic [9:0] HDR_LONG  = 10'h200;

  // Depth code to bits per pixel
  function automatic logic [4:0] bpp_of(input logic [2:0] code);
    case (code)
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd0:    return 5'd0;
      default: return 5'd16;
    endcase
  endfunction

  // Bytes between buffer base and first pixel
  function automatic logic [9:0] hdr_of(input logic [2:0] code, input logic pix_only);
    if (pix_only)          return 10'd0;
    else if (code >= 3'd3) return HDR_LONG;
    else                   return HDR_SHORT;
  endfunction

endpackage

// File: rtl/fbf_pal_ld.sv
module fbf_pal_ld #(
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int PAL_N = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [AW-1:0]            base_i,
  output logic                     rd_req_o,
  output logic [AW-1:0]            rd_addr_o,
  input  logic                     rd_gnt_i,
  input  logic                     rd_vld_i,
  input  logic [DW-1:0]            rd_data_i,
  output logic                     pal_wr_o,
  output logic [$clog2(PAL_N)-1:0] pal_idx_o,
  output logic [DW-1:0]            pal_data_o,
  output logic [2:0]               code_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int IDX_W = $clog2(PAL_N);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] req_cnt, rsp_cnt;
  logic [AW-1:0]    base_q;

  assign rd_req_o  = busy_o && (req_cnt < CNT_W'(PAL_N));
  assign rd_addr_o = base_q + (AW'(req_cnt) << 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      req_cnt    <= '0;
      rsp_cnt    <= '0;
      base_q     <= '0;
      code_o     <= '0;
      pal_wr_o   <= 1'b0;
      pal_idx_o  <= '0;
      pal_data_o <= '0;
    end else begin
      pal_wr_o <= 1'b0;
      done_o   <= 1'b0;
      if (start_i) begin
        busy_o  <= 1'b1;
        base_q  <= base_i;
        req_cnt <= '0;
        rsp_cnt <= '0;
      end else if (busy_o) begin
        if (rd_req_o && rd_gnt_i) req_cnt <= req_cnt + 1'b1;
        if (rd_vld_i) begin
          pal_wr_o   <= 1'b1;
          pal_idx_o  <= rsp_cnt[IDX_W-1:0];
          pal_data_o <= rd_data_i;
          if (rsp_cnt == '0) code_o <= rd_data_i[14:12];
          rsp_cnt <= rsp_cnt + 1'b1;
          if (rsp_cnt == CNT_W'(PAL_N - 1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o)); // R4

  AST_DONE_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rd_vld_i)); // R3

endmodule

// File: rtl/fbf_geom.sv
module fbf_geom
  import fbf_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 10
) (
  input  logic [2:0]    code_i,
  input  logic          pix_only_i,
  input  logic [LW-1:0] w_m1_i,
  input  logic [LW-1:0] h_m1_i,
  input  logic [31:0]   sub_i,
  input  logic [AW-1:0] top_i,
  input  logic [AW-1:0] bot_i,
  output logic [4:0]    bpp_o,
  output logic [9:0]    hdr_o,
  output logic [LW+2:0] stride_o,
  output logic          too_big_o,
  output logic [LW-1:0] first_o,
  output logic [LW:0]   lines_o
);
  localparam int DIM_W  = LW + 1;
  localparam int PROD_W = 2 * DIM_W + 5;
  localparam int LINE_W = DIM_W + 5;
  localparam int CMP_W  = ((AW > PROD_W) ? AW : PROD_W) + 2;

  function automatic logic [PROD_W-1:0] frame_bytes(input logic [DIM_W-1:0] w,
                                                    input logic [DIM_W-1:0] h,
                                                    input logic [4:0] bpp);
    logic [PROD_W-1:0] p;
    p = PROD_W'(w) * PROD_W'(h) * PROD_W'(bpp);
    return p >> 3;
  endfunction

  function automatic logic [LW+2:0] line_bytes(input logic [DIM_W-1:0] w,
                                               input logic [4:0] bpp);
    logic [LINE_W-1:0] p;
    p = LINE_W'(w) * LINE_W'(bpp);
    return p[LINE_W-1:3];
  endfunction

  function automatic logic fits(input logic [CMP_W-1:0] need,
                                input logic [AW-1:0] top,
                                input logic [AW-1:0] bot);
    logic [CMP_W-1:0] room;
    if (bot < top) return 1'b0;
    room = CMP_W'(bot) - CMP_W'(top) + CMP_W'(2);
    return need <= room;
  endfunction

  logic [DIM_W-1:0] w, h;
  logic [CMP_W-1:0] need;
  logic             sub_on, sub_first;
  logic [LW-1:0]    sub_val;

  assign w         = DIM_W'(w_m1_i) + DIM_W'(1);
  assign h         = DIM_W'(h_m1_i) + DIM_W'(1);
  assign bpp_o     = bpp_of(code_i);
  assign hdr_o     = hdr_of(code_i, pix_only_i);
  assign stride_o  = line_bytes(w, bpp_o);
  assign need      = CMP_W'(hdr_o) + CMP_W'(frame_bytes(w, h, bpp_o));
  assign too_big_o = !fits(need, top_i, bot_i);

  assign sub_on    = sub_i[31];
  assign sub_first = sub_i[29];
  assign sub_val   = sub_i[16 +: LW];

  always_comb begin
    first_o = '0;
    lines_o = h;
    if (sub_on) begin
      if (sub_first) first_o = sub_val;
      else           lines_o = DIM_W'(sub_val);
    end
  end

endmodule

// File: rtl/fbf_seq.sv
module fbf_seq
  import fbf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int LW    = 10,
  parameter int PAL_N = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_req_i,
  input  logic [1:0]               load_mode_i,
  input  logic                     dual_i,
  input  logic                     err_irq_en_i,
  input  logic [LW-1:0]            width_m1_i,
  input  logic [LW-1:0]            height_m1_i,
  input  logic [31:0]              subpanel_i,
  input  logic [AW-1:0]            top0_i,
  input  logic [AW-1:0]            bot0_i,
  input  logic [AW-1:0]            top1_i,
  input  logic [AW-1:0]            bot1_i,
  input  logic [3:0]               addr_ok_i,
  input  logic                     tick_i,
  output logic                     rd_req_o,
  output logic [AW-1:0]            rd_addr_o,
  input  logic                     rd_gnt_i,
  input  logic                     rd_vld_i,
  input  logic [DW-1:0]            rd_data_i,
  output logic                     pal_wr_o,
  output logic [$clog2(PAL_N)-1:0] pal_idx_o,
  output logic [DW-1:0]            pal_data_o,
  output logic                     pal_done_o,
  output logic                     run_o,
  output logic                     frame_go_o,
  output logic                     frame_skip_o,
  output logic                     sync_err_o,
  output logic [2:0]               cond_set_o,
  output logic                     err_irq_o,
  output logic [AW-1:0]            pix_base_o,
  output logic [4:0]               bpp_o,
  output logic [LW+2:0]            stride_o,
  output logic [LW-1:0]            first_line_o,
  output logic [LW:0]              line_cnt_o
);
  seq_st_t       st;
  logic          en_q, cur, frame_ld;
  logic [AW-1:0] base0, base1, ld_base;
  logic          ld_start, ld_busy, ld_done;
  logic [2:0]    ld_code;

  // named internal events
  logic          en_rise, bufs_ok, pix_only;
  logic [AW-1:0] cur_base, cur_top, cur_bot;
  logic [4:0]    g_bpp;
  logic [9:0]    g_hdr;
  logic [LW+2:0] g_stride;
  logic          g_too_big;
  logic [LW-1:0] g_first;
  logic [LW:0]   g_lines;

  assign en_rise  = en_req_i && !en_q;
  assign bufs_ok  = addr_ok_i[0] && addr_ok_i[1] &&
                    (!dual_i || (addr_ok_i[2] && addr_ok_i[3]));
  assign pix_only = (load_mode_i == LM_PIXONLY);
  assign cur_base = cur ? base1 : base0;
  assign cur_top  = cur ? top1_i : top0_i;
  assign cur_bot  = cur ? bot1_i : bot0_i;

  fbf_pal_ld #(.AW(AW), .DW(DW), .PAL_N(PAL_N)) u_ld (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (ld_start),
    .base_i    (ld_base),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_gnt_i  (rd_gnt_i),
    .rd_vld_i  (rd_vld_i),
    .rd_data_i (rd_data_i),
    .pal_wr_o  (pal_wr_o),
    .pal_idx_o (pal_idx_o),
    .pal_data_o(pal_data_o),
    .code_o    (ld_code),
    .busy_o    (ld_busy),
    .done_o    (ld_done)
  );

  fbf_geom #(.AW(AW), .LW(LW)) u_geom (
    .code_i    (ld_code),
    .pix_only_i(pix_only),
    .w_m1_i    (width_m1_i),
    .h_m1_i    (height_m1_i),
    .sub_i     (subpanel_i),
    .top_i     (cur_top),
    .bot_i     (cur_bot),
    .bpp_o     (g_bpp),
    .hdr_o     (g_hdr),
    .stride_o  (g_stride),
    .too_big_o (g_too_big),
    .first_o   (g_first),
    .lines_o   (g_lines)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      en_q         <= 1'b0;
      cur          <= 1'b0;
      frame_ld     <= 1'b0;
      base0        <= '0;
      base1        <= '0;
      ld_base      <= '0;
      ld_start     <= 1'b0;
      run_o        <= 1'b0;
      pal_done_o   <= 1'b0;
      frame_go_o   <= 1'b0;
      frame_skip_o <= 1'b0;
      sync_err_o   <= 1'b0;
      cond_set_o   <= '0;
      err_irq_o    <= 1'b0;
      pix_base_o   <= '0;
      bpp_o        <= '0;
      stride_o     <= '0;
      first_line_o <= '0;
      line_cnt_o   <= '0;
    end else begin
      en_q         <= en_req_i;
      ld_start     <= 1'b0;
      pal_done_o   <= 1'b0;
      frame_go_o   <= 1'b0;
      frame_skip_o <= 1'b0;
      sync_err_o   <= 1'b0;
      cond_set_o   <= '0;
      err_irq_o    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (en_rise) begin
            if (!bufs_ok) begin
              cond_set_o <= 3'b100;
              err_irq_o  <= err_irq_en_i;
            end else begin
              base0 <= top0_i;
              base1 <= top1_i;
              cur   <= 1'b0;
              run_o <= 1'b1;
              if (pix_only) begin
                st <= S_WAIT;
              end else begin
                ld_start <= 1'b1;
                ld_base  <= top0_i;
                frame_ld <= 1'b0;
                st       <= S_LOAD;
              end
            end
          end
        end
        S_WAIT: begin
          if (!en_req_i) begin
            run_o <= 1'b0;
            st    <= S_IDLE;
          end else if (tick_i && load_mode_i != LM_OFF) begin
            if (pix_only) begin
              st <= S_EVAL;
            end else begin
              ld_start <= 1'b1;
              ld_base  <= cur_base;
              frame_ld <= 1'b1;
              st       <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (ld_done) begin
            if (frame_ld) begin
              st <= S_EVAL;
            end else begin
              pal_done_o <= 1'b1;
              st         <= S_WAIT;
            end
          end
        end
        S_EVAL: begin
          if (ld_code == 3'd0) begin
            frame_skip_o <= 1'b1;
            st           <= S_WAIT;
          end else if (g_too_big) begin
            sync_err_o <= 1'b1;
            run_o      <= 1'b0;
            st         <= S_IDLE;
          end else begin
            frame_go_o   <= 1'b1;
            cond_set_o   <= cur ? 3'b010 : 3'b001;
            pix_base_o   <= cur_base + AW'(g_hdr);
            bpp_o        <= g_bpp;
            stride_o     <= g_stride;
            first_line_o <= g_first;
            line_cnt_o   <= g_lines;
            if (dual_i) cur <= ~cur;
            st <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> !run_o); // R8

  AST_BUF_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go_o && $past(dual_i) |-> cur != $past(cur)); // R9

  AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_set_o)); // R9

  AST_NO_LOAD_PIXONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_busy) |-> $past(load_mode_i, 2) != LM_PIXONLY); // R3

  AST_ADDR_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_set_o[2] |-> !run_o); // R2

endmodule

// File: tb/fbf_seq_tb.sv
module fbf_seq_tb;
  localparam int AW = 32, DW = 16, LW = 10, PAL_N = 256;
  localparam int NV = 12;
  // {code, mode, w_m1, h_m1, submode, subval, size, kind(0 go,1 skip,2 err), bpp, off}
  localparam logic [77:0] VEC [NV] = '{
    {3'd1, 2'd0, 10'd15,   10'd7,    2'd0, 10'd0, 24'h001000, 2'd0, 5'd2,  10'h020},
    {3'd2, 2'd0, 10'd31,   10'd3,    2'd0, 10'd0, 24'h001000, 2'd0, 5'd4,  10'h020},
    {3'd3, 2'd0, 10'd63,   10'd7,    2'd0, 10'd0, 24'h001000, 2'd0, 5'd8,  10'h200},
    {3'd5, 2'd0, 10'd63,   10'd15,   2'd0, 10'd0, 24'h001000, 2'd0, 5'd16, 10'h200},
    {3'd0, 2'd0, 10'd15,   10'd7,    2'd0, 10'd0, 24'h001000, 2'd1, 5'd0,  10'h000},
    {3'd3, 2'd0, 10'd63,   10'd7,    2'd0, 10'd0, 24'h0003FE, 2'd0, 5'd8,  10'h200},
    {3'd3, 2'd0, 10'd63,   10'd7,    2'd0, 10'd0, 24'h0003FD, 2'd2, 5'd0,  10'h000},
    {3'd7, 2'd2, 10'd63,   10'd7,    2'd0, 10'd0, 24'h001000, 2'd0, 5'd8,  10'h000},
    {3'd6, 2'd0, 10'd15,   10'd15,   2'd3, 10'd5, 24'h001000, 2'd0, 5'd16, 10'h200},
    {3'd2, 2'd3, 10'd15,   10'd15,   2'd2, 10'd3, 24'h001000, 2'd0, 5'd4,  10'h020},
    {3'd4, 2'd0, 10'd1023, 10'd1023, 2'd0, 10'd0, 24'h2001FE, 2'd0, 5'd16, 10'h200},
    {3'd4, 2'd0, 10'd1023, 10'd1023, 2'd0, 10'd0, 24'h2001FD, 2'd2, 5'd0,  10'h000}
  };

  logic clk = 0, rst_n = 0;
  logic en_req = 0, dual = 0, err_en = 0, tick = 0;
  logic [1:0] mode = 0;
  logic [LW-1:0] wm1 = 0, hm1 = 0;
  logic [31:0] sub = 0;
  logic [AW-1:0] top0 = 32'h1000, bot0 = 32'h2000, top1 = 32'h8000, bot1 = 32'h9000;
  logic [3:0] aok = 4'hf;
  logic rd_req, rd_gnt, rd_vld = 0, pal_wr, pal_done, run, go, skip, serr, eirq;
  logic [AW-1:0] rd_addr, pix_base;
  logic [DW-1:0] rd_data = 0, pal_data;
  logic [7:0] pal_idx;
  logic [2:0] cond;
  logic [4:0] bpp;
  logic [LW+2:0] stride;
  logic [LW-1:0] first;
  logic [LW:0] lines;

  fbf_seq #(.AW(AW), .DW(DW), .LW(LW), .PAL_N(PAL_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .load_mode_i(mode), .dual_i(dual),
    .err_irq_en_i(err_en), .width_m1_i(wm1), .height_m1_i(hm1), .subpanel_i(sub),
    .top0_i(top0), .bot0_i(bot0), .top1_i(top1), .bot1_i(bot1), .addr_ok_i(aok),
    .tick_i(tick), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt),
    .rd_vld_i(rd_vld), .rd_data_i(rd_data), .pal_wr_o(pal_wr), .pal_idx_o(pal_idx),
    .pal_data_o(pal_data), .pal_done_o(pal_done), .run_o(run), .frame_go_o(go),
    .frame_skip_o(skip), .sync_err_o(serr), .cond_set_o(cond), .err_irq_o(eirq),
    .pix_base_o(pix_base), .bpp_o(bpp), .stride_o(stride), .first_line_o(first),
    .line_cnt_o(lines)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic stall = 0;
  logic [15:0] word0 = 0;
  logic [AW-1:0] ld_base = 0;
  int gnt_cnt = 0, wr_cnt = 0, pal_bad = 0;
  bit ev_go, ev_skip, ev_err, ev_c2, ev_irq, ev_pd;
  logic [2:0] go_cond;
  logic [AW-1:0] go_base;
  logic [4:0] go_bpp;
  logic [LW+2:0] go_stride;
  logic [LW-1:0] go_first;
  logic [LW:0] go_lines;

  function automatic logic [15:0] memf(input logic [AW-1:0] a);
    return (a[8:0] == 9'd0) ? word0 : (a[15:0] ^ 16'h5a5a);
  endfunction

  // memory model: grant with optional stalls, data one cycle after grant
  assign rd_gnt = !stall || (cyc % 3 != 0);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_vld <= rd_req && rd_gnt;
    rd_data <= memf(rd_addr);
    if (rd_req && rd_gnt) begin
      gnt_cnt = gnt_cnt + 1;
      if (rd_addr[8:0] == 9'd0) ld_base = rd_addr;
    end
  end

  always @(negedge clk) begin
    if (pal_wr) begin
      wr_cnt = wr_cnt + 1;
      if (pal_data !== memf(ld_base + {pal_idx, 1'b0})) pal_bad = pal_bad + 1;
    end
    if (pal_done) ev_pd = 1;
    if (skip) ev_skip = 1;
    if (serr) ev_err = 1;
    if (cond[2]) ev_c2 = 1;
    if (eirq) ev_irq = 1;
    if (go) begin
      ev_go = 1; go_cond = cond; go_base = pix_base; go_bpp = bpp;
      go_stride = stride; go_first = first; go_lines = lines;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_ev();
    ev_go = 0; ev_skip = 0; ev_err = 0; ev_c2 = 0; ev_irq = 0; ev_pd = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pd();
    for (int i = 0; i < 4000 && !ev_pd; i++) @(negedge clk);
  endtask

  task automatic do_tick(output int kind);
    clr_ev();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    kind = 3;
    for (int i = 0; i < 4000; i++) begin
      if (ev_go) begin kind = 0; break; end
      if (ev_skip) begin kind = 1; break; end
      if (ev_err) begin kind = 2; break; end
      @(negedge clk);
    end
  endtask

  task automatic enable_fresh();
    @(negedge clk) en_req = 0;
    cycles(3);
    clr_ev();
    @(negedge clk) en_req = 1;
    cycles(2);
    if (mode != 2'd2) wait_pd();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int kind;
    logic [77:0] v;
    logic [2:0] vcode; logic [1:0] vmode, vsm, vkind; logic [9:0] vw, vh, vsv, voff;
    logic [23:0] vsize; logic [4:0] vbpp;
    int exp_first, exp_lines, exp_stride, gc0;

    cycles(3);
    // R1: reset state
    chk(run == 0 && rd_req == 0, "R1 run/req after reset", {run, rd_req}, 0);
    chk({go, skip, serr, eirq, pal_wr, pal_done} == 0 && cond == 0,
        "R1 pulses after reset", {go, skip, serr, eirq, pal_wr, pal_done, cond}, 0);
    @(negedge clk) rst_n = 1;
    cycles(2);

    // table-driven vectors
    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      {vcode, vmode, vw, vh, vsm, vsv, vsize, vkind, vbpp, voff} = v;
      stall = n[0];
      @(negedge clk) en_req = 0;
      word0 = {1'b0, vcode, 12'h0ab};
      mode = vmode; wm1 = vw; hm1 = vh; dual = 0; aok = 4'hf;
      sub = {vsm[1], 1'b0, vsm[0], 3'b000, vsv, 16'h0000};
      top0 = 32'h1000; bot0 = 32'h1000 + {8'h0, vsize};
      enable_fresh();
      if (vmode != 2'd2) chk(ev_pd, "R3 start-up table load done", ev_pd, 1);
      do_tick(kind);
      chk(kind == int'(vkind), $sformatf("R6 R8 outcome vector %0d", n), kind, vkind);
      if (kind == 0 && vkind == 2'd0) begin
        chk(go_bpp == vbpp, $sformatf("R6 bpp vector %0d", n), go_bpp, vbpp);
        chk(go_base == 32'h1000 + voff, $sformatf("R7 pixel base vector %0d", n),
            go_base, 32'h1000 + voff);
        exp_stride = ((int'(vw) + 1) * int'(vbpp)) / 8;
        chk(int'(go_stride) == exp_stride, $sformatf("R7 stride vector %0d", n),
            go_stride, exp_stride);
        if (vsm == 2'd3) begin exp_first = vsv; exp_lines = int'(vh) + 1; end
        else if (vsm == 2'd2) begin exp_first = 0; exp_lines = vsv; end
        else begin exp_first = 0; exp_lines = int'(vh) + 1; end
        chk(int'(go_first) == exp_first && int'(go_lines) == exp_lines,
            $sformatf("R10 window vector %0d", n), {go_first, go_lines},
            {exp_first[9:0], exp_lines[10:0]});
        chk(go_cond == 3'b001, $sformatf("R9 condition vector %0d", n), go_cond, 1);
      end
      if (vkind == 2'd2) begin
        cycles(2);
        chk(run == 0, $sformatf("R8 run drops vector %0d", n), run, 0);
      end
    end
    chk(pal_bad == 0, "R3 R5 table words match memory", pal_bad, 0);
    chk(gnt_cnt == wr_cnt, "R4 grants equal forwarded words", gnt_cnt, wr_cnt);

    // R8: after sync error, ticks ignored while enable stays high
    stall = 0;
    do_tick(kind);
    chk(kind == 3 && run == 0, "R8 tick ignored after error", kind, 3);

    // R2: address validity
    @(negedge clk) en_req = 0;
    mode = 0; dual = 0; aok = 4'b1101; err_en = 1;
    cycles(3); clr_ev();
    @(negedge clk) en_req = 1;
    cycles(4);
    chk(ev_c2 && ev_irq && run == 0, "R2 bad bottom raises error",
        {ev_c2, ev_irq, run}, 3'b110);
    @(negedge clk) en_req = 0;
    dual = 1; aok = 4'b0011; err_en = 0;
    cycles(3); clr_ev();
    @(negedge clk) en_req = 1;
    cycles(4);
    chk(ev_c2 && !ev_irq && run == 0, "R2 dual checks second buffer, irq masked",
        {ev_c2, ev_irq, run}, 3'b100);
    dual = 0;
    enable_fresh();
    chk(run == 1 && !ev_c2, "R2 single mode ignores second buffer flags", {run, ev_c2}, 2'b10);

    // R9: dual alternation
    @(negedge clk) en_req = 0;
    dual = 1; aok = 4'hf; word0 = 16'h3000; wm1 = 63; hm1 = 7; sub = 0;
    top0 = 32'h1000; bot0 = 32'h2000; top1 = 32'h8000; bot1 = 32'h9000;
    enable_fresh();
    do_tick(kind);
    chk(kind == 0 && go_cond == 3'b001 && go_base == 32'h1200, "R9 dual frame 1 buffer 0",
        {go_cond, go_base}, {3'b001, 32'h1200});
    do_tick(kind);
    chk(kind == 0 && go_cond == 3'b010 && go_base == 32'h8200, "R9 dual frame 2 buffer 1",
        {go_cond, go_base}, {3'b010, 32'h8200});
    do_tick(kind);
    chk(kind == 0 && go_cond == 3'b001 && go_base == 32'h1200, "R9 dual frame 3 buffer 0",
        {go_cond, go_base}, {3'b001, 32'h1200});
    chk(pal_bad == 0, "R5 reload from current buffer", pal_bad, 0);

    // R12: drop enable then restart at buffer 0
    do_tick(kind);
    @(negedge clk) en_req = 0;
    cycles(3);
    chk(run == 0, "R12 run falls on disable", run, 0);
    enable_fresh();
    do_tick(kind);
    chk(kind == 0 && go_cond == 3'b001, "R12 restart from buffer 0", go_cond, 1);

    // R11: load mode 1 suppresses frames
    @(negedge clk) en_req = 0;
    mode = 2'd1; dual = 0;
    enable_fresh();
    gc0 = gnt_cnt;
    do_tick(kind);
    chk(kind == 3 && gnt_cnt == gc0, "R11 no reads or outcome in mode 1",
        gnt_cnt - gc0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule